// File: doc/BRIEF.md
# Per-Core Supply Rail Selector

This block picks a supply rail for every core of a sixteen-core cluster. Each core has a critical-path monitor that reports the highest frequency the core can reach on each of three rails: low, typical and high. When a calibration strobe arrives, the block compares those readings with one shared target frequency. Each core gets the lowest rail that still meets the target. A core that misses the target on every rail is marked unusable and is kept out of service.

Level shifters connect each core to the shared cluster logic, so a core's rail cannot change while the core is running. For each rail move the block first stops that core's clock. It then changes the rail code and waits a fixed settle interval for the shifters, and only after that does it enable the clock again. Calibration walks the cores in ascending index order and performs one rail move at a time. A done flag rises after the last core has been handled.

Top module: `rail_selector`

## Requirements
- R1: After reset every core is on the low rail (code 0), every core clock enable is 1, every unusable flag is 0 and the done flag is 0.
- R2: Rail codes are 2 bits: low = 0, typical = 1, high = 2. Code 3 never appears. Calibration gives each core the lowest rail whose reading is greater than or equal to the target, so a reading equal to the target counts as meeting it.
- R3: A core whose three readings are all below the target gets rail code 2, its unusable flag set and its clock enable held at 0. If the core was already flagged, nothing about it changes.
- R4: When a core's rail moves, its clock enable drops in the same cycle the new code appears. The enable stays at 0 for exactly SETTLE_CYCLES cycles (16 by default) and then returns to 1.
- R5: Cores are handled in ascending index order, and at most one usable core has its clock gated at any time.
- R6: The done flag clears on the first clock edge of a calibration. It is set 2*NCORE + SETTLE_CYCLES*m cycles after that edge, where m is the number of settled rail moves in the run.
- R7: A start strobe that arrives while a calibration is running is ignored. It neither restarts the run nor lengthens it.
- R8: A usable core that is already on its chosen rail is left alone: its clock is not gated and its rail code does not change.
- R9: A flagged core whose readings now meet the target goes through the full gated, settled rail move, and its unusable flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calStart | input | 1 | One-cycle strobe that starts a calibration |
| targetFreq | input | FW | Shared target frequency |
| cpmLowFreq | input | NCORE*FW | Monitor readings on the low rail, core i at bits [i*FW +: FW] |
| cpmTypFreq | input | NCORE*FW | Monitor readings on the typical rail, same packing |
| cpmHighFreq | input | NCORE*FW | Monitor readings on the high rail, same packing |
| railSel | output | 2*NCORE | Rail code for each core, core i at bits [2i +: 2] |
| coreClkEn | output | NCORE | Clock enable for each core |
| coreUnusable | output | NCORE | Set for cores that cannot meet the target on any rail |
| calDone | output | 1 | Calibration complete |

## Verification
A rail move shows up on the outputs in the cycle after its core is evaluated: the new code and the dropped enable appear together. The enable comes back exactly SETTLE_CYCLES cycles later. The done flag follows the start edge by 2*NCORE plus SETTLE_CYCLES for each settled move. The bench computes the expected move list and the expected latency from the readings before each run, and samples at falling edges. Its monitor starts timing a move at the sample where the code or the enable first changes, and counts the low samples until the enable rises. The bench counts the cycles from the start edge to the done flag and compares that count with the precomputed latency, so any extra or missing cycle on either path is caught.

// File: rtl/rail_pkg.sv
package rail_pkg;
  typedef enum logic [1:0] {
    RAIL_LOW  = 2'd0,
    RAIL_TYP  = 2'd1,
    RAIL_HIGH = 2'd2
  } railT;

  typedef struct packed {
    logic applyRail;  // gate the clock and load the chosen rail
    logic markBad;    // flag the core as unusable and hold it gated
    logic ungate;     // settle interval elapsed, enable the clock again
  } ctlStrobeT;
endpackage

// File: rtl/rail_datapath.sv
module rail_datapath
  import rail_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int FW    = 12,
  localparam int IDXW = $clog2(NCORE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDXW-1:0]    curIdx,
  input  ctlStrobeT          strobe,
  input  logic [FW-1:0]      targetFreq,
  input  logic [NCORE*FW-1:0] lowVec,
  input  logic [NCORE*FW-1:0] typVec,
  input  logic [NCORE*FW-1:0] highVec,
  output logic               needSwitch,
  output logic               needBad,
  output logic [2*NCORE-1:0] railOut,
  output logic [NCORE-1:0]   enOut,
  output logic [NCORE-1:0]   badOut
);
  logic [FW-1:0] lowArr  [NCORE];
  logic [FW-1:0] typArr  [NCORE];
  logic [FW-1:0] highArr [NCORE];
  railT          railQ   [NCORE];
  logic [NCORE-1:0] enQ, badQ;
  railT wantRail;
  logic wantBad;

  always_comb begin
    wantBad  = 1'b0;
    wantRail = RAIL_HIGH;
    if (lowArr[curIdx] >= targetFreq)       wantRail = RAIL_LOW;
    else if (typArr[curIdx] >= targetFreq)  wantRail = RAIL_TYP;
    else if (highArr[curIdx] >= targetFreq) wantRail = RAIL_HIGH;
    else                                    wantBad  = 1'b1;
    needBad    = wantBad && !badQ[curIdx];
    needSwitch = !wantBad && (badQ[curIdx] || (wantRail != railQ[curIdx]));
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign lowArr[i]  = lowVec[i*FW +: FW];
    assign typArr[i]  = typVec[i*FW +: FW];
    assign highArr[i] = highVec[i*FW +: FW];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        railQ[i] <= RAIL_LOW;
        enQ[i]   <= 1'b1;
        badQ[i]  <= 1'b0;
      end else if (curIdx == IDXW'(i)) begin
        if (strobe.markBad) begin
          railQ[i] <= RAIL_HIGH;
          enQ[i]   <= 1'b0;
          badQ[i]  <= 1'b1;
        end else if (strobe.applyRail) begin
          railQ[i] <= wantRail;
          enQ[i]   <= 1'b0;
          badQ[i]  <= 1'b0;
        end else if (strobe.ungate) begin
          enQ[i]   <= 1'b1;
        end
      end
    end

    assign railOut[2*i +: 2] = railQ[i];
    assign enOut[i]          = enQ[i];
    assign badOut[i]         = badQ[i];

    assert_rail_code_R2: assert property (@(posedge clk) disable iff (!rstN)
      railOut[2*i +: 2] != 2'd3);
    assert_bad_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
      badQ[i] |-> !enQ[i]);
    assert_rail_move_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(railQ[i]) |-> !enQ[i]);
  end
endmodule

// File: rtl/rail_control.sv
module rail_control
  import rail_pkg::*;
#(
  parameter int NCORE         = 16,
  parameter int SETTLE_CYCLES = 16,
  localparam int IDXW = $clog2(NCORE),
  localparam int CW   = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            calStart,
  input  logic            needSwitch,
  input  logic            needBad,
  output logic [IDXW-1:0] curIdx,
  output ctlStrobeT       strobe,
  output logic            calDone
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_SETTLE, S_STEP} stateT;
  localparam logic [CW-1:0]   CNT_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NCORE - 1);

  stateT state;
  logic [CW-1:0] settleCnt;

  always_comb begin
    strobe.applyRail = (state == S_EVAL) && needSwitch;
    strobe.markBad   = (state == S_EVAL) && needBad;
    strobe.ungate    = (state == S_SETTLE) && (settleCnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curIdx    <= '0;
      settleCnt <= '0;
      calDone   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (calStart) begin
          curIdx  <= '0;
          calDone <= 1'b0;
          state   <= S_EVAL;
        end
        S_EVAL: begin
          settleCnt <= '0;
          state     <= needSwitch ? S_SETTLE : S_STEP;
        end
        S_SETTLE: begin
          settleCnt <= settleCnt + 1'b1;
          if (settleCnt == CNT_LAST) state <= S_STEP;
        end
        S_STEP: begin
          if (curIdx == IDX_LAST) begin
            calDone <= 1'b1;
            state   <= S_IDLE;
          end else begin
            curIdx <= curIdx + 1'b1;
            state  <= S_EVAL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idx_ascend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVAL && $past(state) == S_STEP) |-> curIdx == $past(curIdx) + 1'b1);
  assert_done_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> $past(curIdx) == IDX_LAST);
  assert_settle_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SETTLE && $past(state) == S_EVAL) |-> settleCnt == '0);
endmodule

// File: rtl/rail_selector.sv
module rail_selector
  import rail_pkg::*;
#(
  parameter int NCORE         = 16,
  parameter int FW            = 12,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calStart,
  input  logic [FW-1:0]       targetFreq,
  input  logic [NCORE*FW-1:0] cpmLowFreq,
  input  logic [NCORE*FW-1:0] cpmTypFreq,
  input  logic [NCORE*FW-1:0] cpmHighFreq,
  output logic [2*NCORE-1:0]  railSel,
  output logic [NCORE-1:0]    coreClkEn,
  output logic [NCORE-1:0]    coreUnusable,
  output logic                calDone
);
  localparam int IDXW = $clog2(NCORE);

  logic [IDXW-1:0] curIdx;
  ctlStrobeT strobe;
  logic needSwitch, needBad;

  rail_control #(.NCORE(NCORE), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .calStart(calStart),
    .needSwitch(needSwitch), .needBad(needBad),
    .curIdx(curIdx), .strobe(strobe), .calDone(calDone)
  );

  rail_datapath #(.NCORE(NCORE), .FW(FW)) u_dp (
    .clk(clk), .rstN(rstN), .curIdx(curIdx), .strobe(strobe),
    .targetFreq(targetFreq), .lowVec(cpmLowFreq), .typVec(cpmTypFreq),
    .highVec(cpmHighFreq), .needSwitch(needSwitch), .needBad(needBad),
    .railOut(railSel), .enOut(coreClkEn), .badOut(coreUnusable)
  );

  assert_one_switch_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~coreClkEn & ~coreUnusable) <= 1);
endmodule

// File: tb/rail_selector_test.sv
module rail_selector_test;
  localparam int NC = 16;
  localparam int FW = 12;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calStart = 1'b0;
  logic [FW-1:0] targetFreq = 12'd830;
  logic [NC*FW-1:0] lowV, typV, highV;
  logic [2*NC-1:0] railSel;
  logic [NC-1:0] coreClkEn, coreUnusable;
  logic calDone;

  always #5 clk = ~clk;

  rail_selector uut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .targetFreq(targetFreq),
    .cpmLowFreq(lowV), .cpmTypFreq(typV), .cpmHighFreq(highV),
    .railSel(railSel), .coreClkEn(coreClkEn), .coreUnusable(coreUnusable),
    .calDone(calDone)
  );

  typedef struct {int core; int rail; bit rise;} evT;
  evT evQ[$];

  int nCmp = 0, nBad = 0;
  int lowR[NC], typR[NC], highR[NC];
  int expRail[NC], expEn[NC], expBadF[NC];
  bit expRise[NC];
  int lowCnt[NC];
  bit monOn = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pick(int l, int t, int h, int tgt);
    if (l >= tgt) return 0;
    if (t >= tgt) return 1;
    if (h >= tgt) return 2;
    return 3;
  endfunction

  task automatic loadReadings();
    for (int i = 0; i < NC; i++) begin
      lowV[i*FW +: FW]  = FW'(lowR[i]);
      typV[i*FW +: FW]  = FW'(typR[i]);
      highV[i*FW +: FW] = FW'(highR[i]);
    end
  endtask

  // monitor: pops an expected move whenever a core's rail or enable changes
  initial begin
    logic [2*NC-1:0] prevRail;
    logic [NC-1:0] prevEn;
    prevRail = '0;
    prevEn = '1;
    forever begin
      @(negedge clk);
      if (monOn) begin
        for (int i = 0; i < NC; i++) begin
          if ((railSel[2*i +: 2] != prevRail[2*i +: 2]) || (prevEn[i] && !coreClkEn[i])) begin
            if (evQ.size() == 0) begin
              chk(0, "R5", "unexpected move on core", i, -1);
            end else begin
              evT e;
              e = evQ.pop_front();
              chk(e.core == i, "R5", "move order core", i, e.core);
              chk(int'(railSel[2*i +: 2]) == e.rail, "R2", "new rail code", int'(railSel[2*i +: 2]), e.rail);
              chk(!coreClkEn[i], "R4", "enable low with new rail", int'(coreClkEn[i]), 0);
              expRise[i] = e.rise;
            end
            lowCnt[i] = 1;
          end else if (!prevEn[i] && coreClkEn[i]) begin
            chk(expRise[i], "R3", "clock re-enabled on core", i, -1);
            chk(lowCnt[i] == SETTLE, "R4", "gated cycles", lowCnt[i], SETTLE);
          end else if (!coreClkEn[i]) begin
            lowCnt[i]++;
          end
        end
      end
      prevRail = railSel;
      prevEn = coreClkEn;
    end
  end

  // driver: computes expected moves and latency, runs a calibration, checks results
  task automatic runCal(input int midPulseAt, input string tag);
    int m = 0;
    int cnt = 0;
    for (int i = 0; i < NC; i++) begin
      int w;
      w = pick(lowR[i], typR[i], highR[i], int'(targetFreq));
      if (w == 3) begin
        if (!expBadF[i]) evQ.push_back('{i, 2, 1'b0});
        expRail[i] = 2; expEn[i] = 0; expBadF[i] = 1;
      end else if (expBadF[i] || w != expRail[i]) begin
        evQ.push_back('{i, w, 1'b1});
        m++;
        expRail[i] = w; expEn[i] = 1; expBadF[i] = 0;
      end
    end
    @(negedge clk) calStart = 1'b1;
    @(posedge clk);
    @(negedge clk) calStart = 1'b0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      calStart = (cnt == midPulseAt);
      if (cnt == 1) chk(!calDone, "R6", "done cleared at start", int'(calDone), 0);
    end while (!calDone && cnt < 5000);
    calStart = 1'b0;
    chk(cnt == 2*NC + SETTLE*m, tag, "start-to-done cycles", cnt, 2*NC + SETTLE*m);
    for (int i = 0; i < NC; i++) begin
      chk(int'(railSel[2*i +: 2]) == expRail[i], "R2", "final rail", int'(railSel[2*i +: 2]), expRail[i]);
      chk(int'(coreClkEn[i]) == expEn[i], "R3", "final enable", int'(coreClkEn[i]), expEn[i]);
      chk(int'(coreUnusable[i]) == expBadF[i], "R9", "final unusable flag", int'(coreUnusable[i]), expBadF[i]);
    end
    chk(evQ.size() == 0, "R8", "moves left unobserved", evQ.size(), 0);
    repeat (40) @(negedge clk);
    chk(calDone, "R7", "done stays set, no restart", int'(calDone), 1);
  endtask

  initial begin
    int lowInit[NC] = '{862, 909, 870, 847, 826, 855, 877, 893, 820, 826, 909, 847, 901, 917, 847, 901};
    for (int i = 0; i < NC; i++) begin
      lowR[i] = lowInit[i];
      typR[i] = lowInit[i] + 80;
      highR[i] = 1400;
      expRail[i] = 0; expEn[i] = 1; expBadF[i] = 0; expRise[i] = 1; lowCnt[i] = 0;
    end
    typR[4] = 829; typR[8] = 829; typR[9] = 829;
    loadReadings();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(railSel == '0, "R1", "rail vector after reset", int'(railSel), 0);
    chk(coreClkEn == '1, "R1", "enables after reset", int'(coreClkEn), 16'hFFFF);
    chk(coreUnusable == '0, "R1", "unusable after reset", int'(coreUnusable), 0);
    chk(!calDone, "R1", "done after reset", int'(calDone), 0);
    monOn = 1;

    // run 1: cores 4, 8, 9 need the high rail
    runCal(-1, "R6");

    // run 2: core0 to typical, core4 back to low at equal reading (R2),
    // core5 fails everywhere (R3), cores 8 and 9 untouched (R8), busy start ignored (R7)
    lowR[0] = 800; typR[0] = 900;
    lowR[4] = 830;
    lowR[5] = 700; typR[5] = 700; highR[5] = 700;
    loadReadings();
    runCal(20, "R7");

    // run 3: core5 restored (R9), core3 high only, core8 typical at equal reading
    lowR[5] = 900; typR[5] = 950; highR[5] = 1400;
    lowR[3] = 700; typR[3] = 800;
    lowR[8] = 829; typR[8] = 830;
    loadReadings();
    runCal(-1, "R9");

    // run 4: nothing changes, no gating at all (R8)
    runCal(5, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule